// File: doc/BRIEF.md
# CAN Message Acceptance Filter

This block decides which of a bank of stored message objects, if any, accepts an incoming CAN frame identifier. Each object carries an identifier, a frame-format flag (standard or extended), a direction bit (transmit or receive) and a valid bit. A filter pass starts on a one-cycle frame strobe. The identifier that comes with it is compared against every object at once. Only the bits selected by a shared, programmable global mask take part in the comparison.

The highest-numbered object is a receive-only catch-all. Its comparison also applies a private mask, ANDed with the global one, so that a whole group of identifiers can land in it. It is chosen only when no other object accepts the frame. When several ordinary objects accept, the lowest-numbered one wins. The verdict, a match flag and the winning index, appears one clock after the strobe. Objects and masks are loaded through a plain single-cycle write port.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is held and after it is released, the match output is 0, the index output is 0, every object is invalid and both masks are all ones. In that state no frame matches.
- R2: A write with address 0 to 14 loads object N = address. The write data fields are: bits [28:0] identifier, bit 29 extended flag (1 = 29-bit frame), bit 30 direction (1 = transmit), bit 31 valid. Address 15 loads the global mask from bits [28:0]. Address 16 loads the last object's private mask from bits [28:0].
- R3: An object is a candidate only if it is valid, set for receive, and its extended flag equals the frame's extended flag.
- R4: A mask bit of 1 requires the frame identifier bit to equal the stored bit, and a mask bit of 0 ignores that bit. Objects 0 to 13 use the global mask only.
- R5: Object 14 compares under the global mask ANDed with its private mask. Its direction bit is forced to receive, whatever value is written.
- R6: For a standard (11-bit) frame, only identifier bits [10:0] take part in the comparison. Frame and stored bits above bit 10 are ignored.
- R7: When several objects accept, the lowest-numbered one is reported. Object 14 is reported only when no object from 0 to 13 accepts.
- R8: The match flag is high for exactly the one cycle after a frame strobe whose identifier is accepted, and the index output then gives the winner. On a miss, or with no strobe, the flag is 0 and the index is 0.
- R9: Writes to addresses 17 to 31 change no object and no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration write address |
| wr_data | input | 32 | Configuration write data |
| rx_valid | input | 1 | Frame identifier strobe, one cycle |
| rx_id | input | 29 | Received identifier (standard frames use bits [10:0]) |
| rx_ext | input | 1 | Received frame is extended |
| hit | output | 1 | An object accepted the frame (cycle after strobe) |
| hit_idx | output | 4 | Index of the accepting object |

## Verification
The bench loads two objects with the same identifier. A filter without the lowest-index rule would report the higher one. It also loads an ordinary object whose identifier falls inside the catch-all's group, which exposes a design that lets the last object win too early. Transmit-set, invalid and format-mismatched objects are each hit with their exact identifier; a design that skipped any candidacy test would wrongly accept. Standard frames are sent with junk in the upper identifier bits, which catches a comparison that is not cut to 11 bits. Clearing a global mask bit, narrowing the private mask, and writing to unused addresses show that each mask acts where it should and that stray writes leave everything unchanged.

// File: rtl/can_flt_pkg.sv
// Package: shared sizes and the stored message-object record for the
// acceptance filter. Assumes identifiers never exceed 29 bits.
package can_flt_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef struct packed {
        logic            valid;
        logic            tx;
        logic            ext;
        logic [ID_W-1:0] id;
    } msg_obj_t;
endpackage

// File: rtl/can_flt_regs.sv
// Configuration store: message objects plus global and last-object masks.
// Assumes one write per cycle; the last object is forced to receive.
module can_flt_regs
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 15,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output msg_obj_t            objs [NUM_OBJ],
    output logic [ID_W-1:0]     gmask,
    output logic [ID_W-1:0]     lmask
);
    localparam int GMASK_ADDR = NUM_OBJ;
    localparam int LMASK_ADDR = NUM_OBJ + 1;

    // Object records, one write decoder per slot
    for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                objs[i] <= '0;
            end else if (wr_en && (int'(wr_addr) == i)) begin
                objs[i].valid <= wr_data[ID_W+2];
                objs[i].tx    <= (i == NUM_OBJ-1) ? 1'b0 : wr_data[ID_W+1];
                objs[i].ext   <= wr_data[ID_W];
                objs[i].id    <= wr_data[ID_W-1:0];
            end
        end
    end

    // Global mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            gmask <= '1;
        else if (wr_en && (int'(wr_addr) == GMASK_ADDR))
            gmask <= wr_data[ID_W-1:0];
    end

    // Last-object private mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            lmask <= '1;
        else if (wr_en && (int'(wr_addr) == LMASK_ADDR))
            lmask <= wr_data[ID_W-1:0];
    end
endmodule

// File: rtl/can_flt_cmp.sv
// Per-object comparator: candidacy test plus masked identifier compare.
// Assumes the effective mask is already formed by the caller; cuts the
// compare to 11 bits for standard frames.
module can_flt_cmp
    import can_flt_pkg::*;
(
    input  msg_obj_t         obj,
    input  logic [ID_W-1:0]  mask,
    input  logic [ID_W-1:0]  rx_id,
    input  logic             rx_ext,
    output logic             accept
);
    localparam logic [ID_W-1:0] STD_MASK = ID_W'((1 << STD_W) - 1);

    logic [ID_W-1:0] width_mask;
    logic [ID_W-1:0] diff;

    // Form the bits that must agree, then check candidacy
    always_comb begin
        width_mask = rx_ext ? '1 : STD_MASK;
        diff       = (obj.id ^ rx_id) & mask & width_mask;
        accept     = obj.valid && !obj.tx && (obj.ext == rx_ext) && (diff == '0);
    end
endmodule

// File: rtl/can_flt_pick.sv
// Priority picker: lowest accepting index wins, so the last object is
// chosen only when no lower one accepts.
module can_flt_pick #(
    parameter int NUM_OBJ = 15,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_OBJ-1:0] acc,
    output logic               any,
    output logic [IDX_W-1:0]   win
);
    // Scan from the top so the lowest accepting index is written last
    always_comb begin
        any = |acc;
        win = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (acc[i]) win = IDX_W'(i);
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
// Top: message acceptance filter. Compares a strobed frame identifier
// against all objects in parallel and registers the verdict one cycle
// later. A frame in the same cycle as a write sees the old configuration.
module can_accept_filter
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 15,
    parameter int ADDR_W  = 5,
    parameter int IDX_W   = $clog2(NUM_OBJ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rx_valid,
    input  logic [28:0]       rx_id,
    input  logic              rx_ext,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    localparam int DATA_W = ID_W + 3;

    msg_obj_t            objs [NUM_OBJ];
    logic [ID_W-1:0]     gmask;
    logic [ID_W-1:0]     lmask;
    logic [NUM_OBJ-1:0]  acc;
    logic                any;
    logic [IDX_W-1:0]    win;

    can_flt_regs #(
        .NUM_OBJ (NUM_OBJ),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .objs    (objs),
        .gmask   (gmask),
        .lmask   (lmask)
    );

    // One comparator per object; the last one also applies its own mask
    for (genvar i = 0; i < NUM_OBJ; i++) begin : g_cmp
        logic [ID_W-1:0] eff_mask;
        if (i == NUM_OBJ - 1) begin : g_last
            assign eff_mask = gmask & lmask;
        end else begin : g_plain
            assign eff_mask = gmask;
        end
        can_flt_cmp u_cmp (
            .obj    (objs[i]),
            .mask   (eff_mask),
            .rx_id  (rx_id),
            .rx_ext (rx_ext),
            .accept (acc[i])
        );
    end

    can_flt_pick #(
        .NUM_OBJ (NUM_OBJ),
        .IDX_W   (IDX_W)
    ) u_pick (
        .acc (acc),
        .any (any),
        .win (win)
    );

    // Register the verdict for the cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_idx <= '0;
        end else begin
            hit     <= rx_valid && any;
            hit_idx <= (rx_valid && any) ? win : '0;
        end
    end
endmodule

// File: rtl/can_accept_filter_chk.sv
// Checker for the acceptance filter, attached by bind. Observes ports only.
module can_accept_filter_chk #(
    parameter int NUM_OBJ = 15,
    parameter int IDX_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx
);
    // R8: a match only follows a strobe
    a_r8_hit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(rx_valid));

    // R8: index is zero whenever no match is reported
    a_r8_idx_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0));

    // R7: a reported index names a real object
    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (int'(hit_idx) < NUM_OBJ));

    // R8: a match lasts one cycle unless strobes come back to back
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !$past(rx_valid, 1) == 1'b0 && !rx_valid) |=> !hit);

    // R1: outputs are defined once out of reset
    a_r1_known_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({hit, hit_idx}));
endmodule

bind can_accept_filter can_accept_filter_chk #(
    .NUM_OBJ (NUM_OBJ),
    .IDX_W   (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .hit      (hit),
    .hit_idx  (hit_idx)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic        rx_valid;
    logic [28:0] rx_id;
    logic        rx_ext;
    logic        hit;
    logic [3:0]  hit_idx;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    can_accept_filter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_ext(rx_ext), .hit(hit), .hit_idx(hit_idx)
    );

    // Vector: {ext, id[28:0], exp_hit, exp_idx[3:0]}
    localparam int NV = 12;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 29'h123,      1'b1, 4'd0},   // R7 dup with obj2: lowest wins
        {1'b1, 29'h1ABCDE0,  1'b1, 4'd1},   // R3 extended match
        {1'b1, 29'h1ABCDE1,  1'b0, 4'd0},   // R4 one bit off
        {1'b0, 29'h200,      1'b0, 4'd0},   // R3 transmit object skipped
        {1'b0, 29'h300,      1'b0, 4'd0},   // R3 invalid object skipped
        {1'b0, 29'h555,      1'b0, 4'd0},   // R3 format mismatch
        {1'b1, 29'h555,      1'b1, 4'd5},   // R3 format agrees
        {1'b0, 29'h1FFFF923, 1'b1, 4'd0},   // R6 upper bits ignored
        {1'b0, 29'h705,      1'b1, 4'd14},  // R5 group match in last object
        {1'b0, 29'h701,      1'b1, 4'd7},   // R7 ordinary beats last
        {1'b0, 29'h710,      1'b0, 4'd0},   // R5 outside private mask
        {1'b0, 29'h70F,      1'b1, 4'd14}   // R5 group edge
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] obj(input bit v, input bit tx, input bit ext, input logic [28:0] id);
        return {v, tx, ext, id};
    endfunction

    // Strobe one frame, then check the verdict in the following cycle
    task automatic frame(input string req, input bit ext, input logic [28:0] id,
                         input bit eh, input logic [3:0] ei);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = id; rx_ext = ext;
        @(negedge clk);
        rx_valid = 1'b0;
        check(req, {31'd0, hit}, {31'd0, eh});
        check(req, {28'd0, hit_idx}, {28'd0, ei});
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rx_valid = 1'b0; rx_id = '0; rx_ext = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 hit in reset", {31'd0, hit}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idx after reset", {28'd0, hit_idx}, 32'd0);
        frame("R1 no match after reset", 1'b0, 29'h0, 1'b0, 4'd0);
        frame("R1 no match after reset", 1'b1, 29'h1FFFFFFF, 1'b0, 4'd0);

        // R2 programming
        wr(5'd0,  obj(1, 0, 0, 29'h123));
        wr(5'd1,  obj(1, 0, 1, 29'h1ABCDE0));
        wr(5'd2,  obj(1, 0, 0, 29'h123));
        wr(5'd3,  obj(1, 1, 0, 29'h200));
        wr(5'd4,  obj(0, 0, 0, 29'h300));
        wr(5'd5,  obj(1, 0, 1, 29'h555));
        wr(5'd7,  obj(1, 0, 0, 29'h701));
        wr(5'd14, obj(1, 1, 0, 29'h700));   // R5 transmit bit ignored
        wr(5'd16, 32'h1FFFFFF0);

        for (int k = 0; k < NV; k++)
            frame("R2/R3/R5/R6/R7 table", VEC[k][34], VEC[k][33:5], VEC[k][4], VEC[k][3:0]);

        // R8: no strobe, matching identifier present
        @(negedge clk);
        rx_id = 29'h123; rx_ext = 1'b0;
        @(negedge clk);
        check("R8 no strobe no hit", {31'd0, hit}, 32'd0);
        check("R8 idx zero without strobe", {28'd0, hit_idx}, 32'd0);
        // R8: pulse is one cycle wide
        frame("R8 strobe", 1'b0, 29'h123, 1'b1, 4'd0);
        @(negedge clk);
        check("R8 pulse ends", {31'd0, hit}, 32'd0);

        // R4: clear global mask bit 0
        frame("R4 before mask change", 1'b0, 29'h122, 1'b0, 4'd0);
        wr(5'd15, 32'h1FFFFFFE);
        frame("R4 masked bit ignored", 1'b0, 29'h122, 1'b1, 4'd0);
        frame("R4 masked bit ignored ext", 1'b1, 29'h1ABCDE1, 1'b1, 4'd1);
        frame("R4 unmasked bit still checked", 1'b1, 29'h1ABCDE2, 1'b0, 4'd0);

        // R5: widen private mask to low byte
        wr(5'd16, 32'h1FFFFF00);
        frame("R5 wider group", 1'b0, 29'h7AB, 1'b1, 4'd14);
        frame("R5 outside group", 1'b0, 29'h6AB, 1'b0, 4'd0);

        // R9: stray writes change nothing
        wr(5'd17, 32'h0);
        wr(5'd20, 32'hFFFFFFFF);
        wr(5'd31, 32'h0);
        frame("R9 objects unchanged", 1'b0, 29'h123, 1'b1, 4'd0);
        frame("R9 masks unchanged", 1'b0, 29'h6AB, 1'b0, 4'd0);
        frame("R9 masks unchanged", 1'b0, 29'h122, 1'b1, 4'd0);

        // R1: reset mid-run clears configuration
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        frame("R1 objects cleared by reset", 1'b0, 29'h123, 1'b0, 4'd0);
        wr(5'd6, obj(1, 0, 0, 29'h124));
        frame("R1 global mask restored to ones", 1'b0, 29'h125, 1'b0, 4'd0);
        frame("R1 global mask restored", 1'b0, 29'h124, 1'b1, 4'd6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule